// File: doc/BRIEF.md
# Two-Channel Serial ADC Scan Sequencer

This block is an SPI master that runs a two-channel, 12-bit serial converter. The converter has a one-frame lag: the command byte shifted out in a frame picks the channel for the *next* conversion. The sequencer hides that lag from its user. It builds each command byte from the configuration inputs, inserts the extra frames that a channel change needs, and pairs every returned sample with the channel that was actually converted.

Three triggered scan modes are available: channel 0 alone, channel 1 alone, or both channels. Entering the channel-1 mode first sends a discarded priming frame. Leaving any scan mode sends a restoring channel-0 frame. A single-shot read of either channel can be requested while no scan mode is selected. Each result appears as a 12-bit word with a one-cycle strobe and a channel tag. Triggers that arrive while a sequence is running are dropped and counted.

Top module: `adc_scan_seq`

## Requirements
- R1: Each frame holds `cs_n` low for exactly 16 rising edges of `sclk`. `sclk` rests high whenever `cs_n` is high. `mosi` changes on falling edges and is read by the converter on rising edges, MSB first. The first 8 bits are the command byte and the last 8 bits are zero.
- R2: The command byte has bit 5 = `ext_ref` (1 turns the on-chip reference off), bit 4 = `dual_en`, bit 3 = commanded channel, and bits 1:0 = `pwr_mode`. Bits 7, 6 and 2 are zero. The power mode codes are 0 = chip-select shutdown, 1 = always on, 2 = shutdown after each conversion, and 3 = standby.
- R3: `res_data` is the low 12 bits of the 16-bit word received MSB first on `miso`. `res_valid` pulses for one clock, in the cycle after `cs_n` rises at the end of a result-bearing frame.
- R4: With `scan_mode` = 1 (channel 0 only), each accepted trigger runs one frame with a channel-0 command and emits one result tagged 0.
- R5: Selecting `scan_mode` = 2 (channel 1 only) first runs one frame with a channel-1 command and emits no result. Triggers are accepted only after that frame. Each accepted trigger then runs one channel-1 command frame and emits one result tagged 1.
- R6: With `scan_mode` = 3 (both channels), a trigger runs two frames. The first sends the channel-1 command and yields the channel-0 result. The second sends the channel-0 command and yields the channel-1 result. The channel-0 result is always emitted first.
- R7: Changing away from any nonzero scan mode runs one frame with a channel-0 command and emits no result. It does this before priming a new channel-1 mode.
- R8: When `scan_mode` = 0 and the block is idle, `os_req` starts a read. With `os_ch` = 0 it runs one channel-0 command frame and emits a result tagged 0. With `os_ch` = 1 it runs a discarded channel-1 command frame, then a channel-0 command frame, and emits a result tagged 1.
- R9: An `os_req` is refused if `scan_mode` is nonzero or a sequence is running. A refused request raises `os_busy` for one cycle and starts no frame.
- R10: A trigger that arrives while a sequence is running is dropped. If a scan mode is selected, the trigger adds one to `ovr_cnt`, which saturates at all ones.
- R11: Between frames, `cs_n` stays high for at least two `sclk` periods (4·DIV clocks).
- R12: After reset, `cs_n` = 1, `sclk` = 1, `mosi` = 0, `res_valid` = 0, `os_busy` = 0 and `ovr_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_ref | input | 1 | 1 = external reference in use (sets command bit 5) |
| dual_en | input | 1 | Dual-channel enable placed in command bit 4 |
| pwr_mode | input | 2 | Power mode code placed in command bits 1:0 |
| scan_mode | input | 2 | 0 off, 1 channel 0, 2 channel 1, 3 both |
| trig | input | 1 | Starts one scan sequence |
| os_req | input | 1 | Single-shot read request |
| os_ch | input | 1 | Channel for the single-shot read |
| sclk | output | 1 | Serial clock, rests high |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial command out |
| miso | input | 1 | Serial data in |
| res_data | output | 12 | Converted sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 1 | Channel the result belongs to |
| os_busy | output | 1 | One-cycle refusal of a single-shot request |
| ovr_cnt | output | 4 | Saturating count of dropped triggers |

## Verification
A result is due exactly one clock after `cs_n` rises at the end of its frame. The bench compares `res_valid`, `res_ch` and `res_data` on every clock against a pending expectation. That expectation is armed at the frame end it observed, so a strobe one cycle early or late fails the check. `os_busy` is due one clock after the refused request is sampled and must be low one clock later. The command byte, the edge count and the gap width are checked at each frame's end against a queue of frames that the bench predicts from each stimulus. `ovr_cnt` is read once the sequence has ended.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_OFF  = 2'd0,
    SCAN_CH0  = 2'd1,
    SCAN_CH1  = 2'd2,
    SCAN_DUAL = 2'd3
  } scan_mode_e;

  typedef enum logic [2:0] {
    K_CH0,
    K_CH1,
    K_DUAL,
    K_PRIME,
    K_RESTORE,
    K_OS1
  } seq_kind_e;

  typedef struct packed {
    logic cmd_ch;   // channel commanded for the next conversion
    logic emit;     // frame returns a result to the user
    logic emit_ch;  // channel of the data received in this frame
    logic last;     // final frame of the sequence
  } frame_plan_t;

  function automatic frame_plan_t plan_frame(seq_kind_e k, logic idx);
    frame_plan_t p;
    p = '{cmd_ch: 1'b0, emit: 1'b0, emit_ch: 1'b0, last: 1'b1};
    case (k)
      K_CH0:     p = '{cmd_ch: 1'b0, emit: 1'b1, emit_ch: 1'b0, last: 1'b1};
      K_CH1:     p = '{cmd_ch: 1'b1, emit: 1'b1, emit_ch: 1'b1, last: 1'b1};
      K_DUAL:    p = idx ? '{cmd_ch: 1'b0, emit: 1'b1, emit_ch: 1'b1, last: 1'b1}
                         : '{cmd_ch: 1'b1, emit: 1'b1, emit_ch: 1'b0, last: 1'b0};
      K_PRIME:   p = '{cmd_ch: 1'b1, emit: 1'b0, emit_ch: 1'b0, last: 1'b1};
      K_RESTORE: p = '{cmd_ch: 1'b0, emit: 1'b0, emit_ch: 1'b0, last: 1'b1};
      K_OS1:     p = idx ? '{cmd_ch: 1'b0, emit: 1'b1, emit_ch: 1'b1, last: 1'b1}
                         : '{cmd_ch: 1'b1, emit: 1'b0, emit_ch: 1'b0, last: 1'b0};
      default:   p = '{cmd_ch: 1'b0, emit: 1'b0, emit_ch: 1'b0, last: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_ctl_byte.sv
module adc_ctl_byte (
  input  logic       ext_ref,
  input  logic       dual_en,
  input  logic [1:0] pwr_mode,
  input  logic       ch,
  output logic [7:0] ctl
);
  always_comb begin
    ctl      = 8'h00;
    ctl[5]   = ext_ref;
    ctl[4]   = dual_en;
    ctl[3]   = ch;
    ctl[1:0] = pwr_mode;
  end
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int DIV        = 4,
  parameter int FRAME_BITS = 16,
  parameter int DATA_W     = 12,
  parameter int GAP_SCLK   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  ready,
  output logic                  done,
  output logic [DATA_W-1:0]     rx_word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int HC_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EDGES   = 2 * FRAME_BITS;
  localparam int E_W     = $clog2(EDGES + 1);
  localparam int GAP_CYC = 2 * DIV * GAP_SCLK;
  localparam int G_W     = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {F_IDLE, F_XFER, F_GAP} fst_e;

  fst_e                  st;
  logic [HC_W-1:0]       hc;
  logic [E_W-1:0]        e;
  logic [G_W-1:0]        gap;
  logic [FRAME_BITS-1:0] sh_tx;
  logic [DATA_W-1:0]     sh_rx;

  assign ready = (st == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      hc      <= '0;
      e       <= '0;
      gap     <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (start) begin
            st    <= F_XFER;
            cs_n  <= 1'b0;
            hc    <= '0;
            e     <= '0;
            sh_tx <= tx_word;
          end
        end
        F_XFER: begin
          if (hc == HC_W'(DIV - 1)) begin
            hc <= '0;
            if (e == E_W'(EDGES)) begin
              cs_n    <= 1'b1;
              mosi    <= 1'b0;
              done    <= 1'b1;
              rx_word <= sh_rx;
              gap     <= '0;
              st      <= F_GAP;
            end else begin
              e <= e + 1'b1;
              if (!e[0]) begin
                sclk  <= 1'b0;
                mosi  <= sh_tx[FRAME_BITS-1];
                sh_tx <= {sh_tx[FRAME_BITS-2:0], 1'b0};
              end else begin
                sclk  <= 1'b1;
                sh_rx <= {sh_rx[DATA_W-2:0], miso};
              end
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        F_GAP: begin
          if (gap == G_W'(GAP_CYC - 1)) st <= F_IDLE;
          else                          gap <= gap + 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  // R11
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int DATA_W     = 12,
  parameter int OVR_W      = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_ref,
  input  logic              dual_en,
  input  logic [1:0]        pwr_mode,
  input  logic [1:0]        scan_mode,
  input  logic              trig,
  input  logic              os_req,
  input  logic              os_ch,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              res_ch,
  output logic              os_busy,
  output logic [OVR_W-1:0]  ovr_cnt
);
  localparam int CTL_W = 8;
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} sst_e;

  sst_e        st;
  scan_mode_e  active;
  scan_mode_e  req;
  seq_kind_e   kind;
  logic        fidx;
  frame_plan_t plan;
  logic [CTL_W-1:0]      ctl;
  logic [FRAME_BITS-1:0] tx_word;
  logic                  eng_start, eng_ready, eng_done;
  logic [DATA_W-1:0]     eng_rx;
  logic                  trig_ok, os_ok;

  assign req       = scan_mode_e'(scan_mode);
  assign plan      = plan_frame(kind, fidx);
  assign tx_word   = {ctl, {(FRAME_BITS-CTL_W){1'b0}}};
  assign eng_start = (st == S_LAUNCH) && eng_ready;
  assign trig_ok   = (st == S_IDLE) && (req == active) && (active != SCAN_OFF);
  assign os_ok     = (st == S_IDLE) && (req == SCAN_OFF) && (active == SCAN_OFF);

  adc_ctl_byte u_ctl (
    .ext_ref  (ext_ref),
    .dual_en  (dual_en),
    .pwr_mode (pwr_mode),
    .ch       (plan.cmd_ch),
    .ctl      (ctl)
  );

  adc_spi_frame #(
    .DIV        (DIV),
    .FRAME_BITS (FRAME_BITS),
    .DATA_W     (DATA_W),
    .GAP_SCLK   (2)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_word (tx_word),
    .ready   (eng_ready),
    .done    (eng_done),
    .rx_word (eng_rx),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .miso    (miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      active    <= SCAN_OFF;
      kind      <= K_CH0;
      fidx      <= 1'b0;
      res_data  <= '0;
      res_valid <= 1'b0;
      res_ch    <= 1'b0;
      os_busy   <= 1'b0;
      ovr_cnt   <= '0;
    end else begin
      res_valid <= 1'b0;
      os_busy   <= os_req && !os_ok;
      if (trig && !trig_ok && (req != SCAN_OFF) && (ovr_cnt != OVR_MAX))
        ovr_cnt <= ovr_cnt + 1'b1;
      case (st)
        S_IDLE: begin
          fidx <= 1'b0;
          if (req != active) begin
            if (active != SCAN_OFF) begin
              kind <= K_RESTORE;
              st   <= S_LAUNCH;
            end else if (req == SCAN_CH1) begin
              kind <= K_PRIME;
              st   <= S_LAUNCH;
            end else begin
              active <= req;
            end
          end else if (trig_ok && trig) begin
            case (active)
              SCAN_CH1:  kind <= K_CH1;
              SCAN_DUAL: kind <= K_DUAL;
              default:   kind <= K_CH0;
            endcase
            st <= S_LAUNCH;
          end else if (os_ok && os_req) begin
            kind <= os_ch ? K_OS1 : K_CH0;
            st   <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          if (eng_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            if (plan.emit) begin
              res_valid <= 1'b1;
              res_ch    <= plan.emit_ch;
              res_data  <= eng_rx;
            end
            if (plan.last) begin
              st <= S_IDLE;
              if (kind == K_PRIME)   active <= SCAN_CH1;
              if (kind == K_RESTORE) active <= SCAN_OFF;
            end else begin
              fidx <= 1'b1;
              st   <= S_LAUNCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  busy_on_scan_chk: assert property (@(posedge clk) disable iff (rst)
    (os_req && (scan_mode != 2'd0)) |=> os_busy);

  // R10
  ovr_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovr_cnt >= $past(ovr_cnt)));

  // R1
  frame_idle_mosi_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !mosi);

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_ref = 1'b1, dual_en = 1'b1;
  logic [1:0] pwr_mode = 2'd3, scan_mode = 2'd0;
  logic trig = 1'b0, os_req = 1'b0, os_ch = 1'b0;
  logic sclk, cs_n, mosi, miso = 1'b0;
  logic [11:0] res_data;
  logic res_valid, res_ch, os_busy;
  logic [3:0] ovr_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.DIV(DIV)) i_adc_scan_seq (
    .clk(clk), .rst(rst), .ext_ref(ext_ref), .dual_en(dual_en),
    .pwr_mode(pwr_mode), .scan_mode(scan_mode), .trig(trig),
    .os_req(os_req), .os_ch(os_ch), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .res_data(res_data), .res_valid(res_valid),
    .res_ch(res_ch), .os_busy(os_busy), .ovr_cnt(ovr_cnt)
  );

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  logic [7:0] q_cmd[$];
  bit         q_emit[$];
  bit         q_ch[$];
  string      q_req[$];

  int bench_mode = 0;
  int exp_ovr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_of(input bit ch);
    return {2'b00, ext_ref, dual_en, ch, 1'b0, pwr_mode};
  endfunction

  task automatic expect_frame(input bit ch_cmd, input bit emit, input bit ch, input string req);
    q_cmd.push_back(cmd_of(ch_cmd));
    q_emit.push_back(emit);
    q_ch.push_back(ch);
    q_req.push_back(req);
  endtask

  // converter model and per-clock comparison
  bit         conv_ch = 1'b0;
  logic [11:0] conv_val = '0;
  int          n0 = 0, n1 = 0;
  logic [15:0] slv_word = '0;
  logic [15:0] mosi_sh = '0;
  int          rise_cnt = 0;
  bit          prev_sclk = 1'b1, prev_cs = 1'b1;
  bit          pend = 1'b0, pend_emit = 1'b0, pend_ch = 1'b0;
  logic [11:0] pend_data = '0;
  longint      cyc = 0, last_rise = -1000;
  bit          seen_frame = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (pend) begin
        chk(res_valid == pend_emit, "R3 strobe timing", res_valid, pend_emit);
        if (pend_emit) begin
          chk(res_ch == pend_ch, "R6 channel tag", res_ch, pend_ch);
          chk(res_data == pend_data, "R3 data", res_data, pend_data);
        end
        pend = 1'b0;
      end else if (res_valid) begin
        chk(1'b0, "R3 unexpected strobe", 1, 0);
      end
      if (prev_cs && !cs_n) begin
        if (seen_frame)
          chk(cyc - last_rise >= 4*DIV, "R11 gap", int'(cyc - last_rise), 4*DIV);
        conv_val = conv_ch ? 12'(12'h800 + n1) : 12'(12'h100 + n0);
        if (conv_ch) n1++; else n0++;
        slv_word = {conv_ch ? 4'hA : 4'h5, conv_val};
        rise_cnt = 0;
      end
      if (!cs_n && prev_sclk && !sclk) begin
        miso <= slv_word[15];
        slv_word = {slv_word[14:0], 1'b0};
      end
      if (!cs_n && !prev_sclk && sclk) begin
        mosi_sh = {mosi_sh[14:0], mosi};
        rise_cnt++;
      end
      if (!cs_n) chk_idle_ok: begin end
      if (cs_n && !sclk) chk(1'b0, "R1 sclk low while deselected", 0, 1);
      if (!prev_cs && cs_n) begin
        seen_frame = 1'b1;
        last_rise = cyc;
        chk(rise_cnt == 16, "R1 edge count", rise_cnt, 16);
        chk(mosi_sh[7:0] == 8'h00, "R1 trailing byte", mosi_sh[7:0], 0);
        if (q_cmd.size() == 0) begin
          chk(1'b0, "R1 unexpected frame", mosi_sh[15:8], 0);
        end else begin
          automatic logic [7:0] ec = q_cmd.pop_front();
          automatic bit em = q_emit.pop_front();
          automatic bit ech = q_ch.pop_front();
          automatic string rq = q_req.pop_front();
          chk(mosi_sh[15:8] == ec, {rq, " R2 command byte"}, mosi_sh[15:8], ec);
          if (em) chk(ech == conv_ch, {rq, " converted channel"}, conv_ch, ech);
          pend = 1'b1;
          pend_emit = em;
          pend_ch = ech;
          pend_data = conv_val;
        end
        conv_ch = mosi_sh[12] & mosi_sh[11];
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    if (m != bench_mode) begin
      if (bench_mode != 0) expect_frame(1'b0, 1'b0, 1'b0, "R7");
      if (m == 2) expect_frame(1'b1, 1'b0, 1'b0, "R5");
    end
    bench_mode = m;
    @(negedge clk);
    scan_mode = 2'(m);
    wait_cyc(400);
  endtask

  task automatic fire(input string req);
    if (bench_mode == 1) expect_frame(1'b0, 1'b1, 1'b0, req);
    if (bench_mode == 2) expect_frame(1'b1, 1'b1, 1'b1, req);
    if (bench_mode == 3) begin
      expect_frame(1'b1, 1'b1, 1'b0, req);
      expect_frame(1'b0, 1'b1, 1'b1, req);
    end
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic one_shot(input bit ch);
    if (ch) begin
      expect_frame(1'b1, 1'b0, 1'b0, "R8");
      expect_frame(1'b0, 1'b1, 1'b1, "R8");
    end else begin
      expect_frame(1'b0, 1'b1, 1'b0, "R8");
    end
    @(negedge clk);
    os_req = 1'b1;
    os_ch = ch;
    @(negedge clk);
    os_req = 1'b0;
    chk(os_busy == 1'b0, "R8 accepted request not busy", os_busy, 0);
  endtask

  task automatic refused_shot(input string req);
    @(negedge clk);
    os_req = 1'b1;
    @(negedge clk);
    os_req = 1'b0;
    chk(os_busy == 1'b1, {req, " busy pulse"}, os_busy, 1);
    @(negedge clk);
    chk(os_busy == 1'b0, {req, " busy one cycle"}, os_busy, 0);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cs_n == 1'b1, "R12 cs_n", cs_n, 1);
    chk(sclk == 1'b1, "R12 sclk", sclk, 1);
    chk(mosi == 1'b0, "R12 mosi", mosi, 0);
    chk(res_valid == 1'b0, "R12 res_valid", res_valid, 0);
    chk(os_busy == 1'b0, "R12 os_busy", os_busy, 0);
    chk(ovr_cnt == 4'd0, "R12 ovr_cnt", ovr_cnt, 0);
    rst = 1'b0;
    wait_cyc(5);

    // R8 single shots with scan off
    one_shot(1'b0);
    wait_cyc(400);
    one_shot(1'b1);
    wait_cyc(400);

    // R9 refused while a single shot is running
    one_shot(1'b0);
    wait_cyc(10);
    refused_shot("R9 running");
    wait_cyc(400);

    // R4 channel 0 scan
    set_mode(1);
    fire("R4");
    wait_cyc(400);
    fire("R4");
    wait_cyc(400);
    refused_shot("R9 scan selected");
    wait_cyc(50);

    // R6 dual scan, different configuration
    ext_ref = 1'b0;
    pwr_mode = 2'd1;
    set_mode(3);
    fire("R6");
    wait_cyc(400);

    // R10 overruns during a dual sequence
    fire("R6");
    wait_cyc(40);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    exp_ovr = 3;
    wait_cyc(400);
    chk(ovr_cnt == 4'(exp_ovr), "R10 count", ovr_cnt, exp_ovr);
    fire("R6");
    wait_cyc(40);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    exp_ovr = 15;
    wait_cyc(400);
    chk(ovr_cnt == 4'(exp_ovr), "R10 saturation", ovr_cnt, exp_ovr);

    // R5 / R7 change to channel 1 scan, then switch off
    pwr_mode = 2'd2;
    set_mode(2);
    fire("R5");
    wait_cyc(400);
    fire("R5");
    wait_cyc(400);
    set_mode(0);
    one_shot(1'b0);
    wait_cyc(400);

    chk(q_cmd.size() == 0, "R1 missing frames", q_cmd.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule